// File: doc/BRIEF.md
# Execute-in-place read sequencer for serial NOR flash

This block sits between a simple word-read request port and a single-line serial NOR flash. After reset it prepares the flash for execute-in-place operation and then turns each accepted request into one chip-select frame. It shifts out a command and an address, clocks through a set number of idle (dummy) clocks, and collects a 32-bit word from the flash's serial output. The first confirmed read puts the flash into a continuous-read state. From then on, frames carry only the address, so each access saves eight serial clocks.

The sequencer keeps track of whether the flash is in that continuous-read state. It drives a confirmation bit on the data-out line during the first dummy clock of every read: a 0 keeps or enters the state, and a 1 leaves it. A level input chooses between continuous reads and plain reads that carry an opcode. A strap input selects parts that enter the state directly without a configuration write. A second strap input selects a 24-bit or 32-bit address on the wire. The number of dummy clocks is a build parameter.

Top module: `xip_read_seq`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, `spi_sck` is 0 and `rsp_valid` is 0. With `basic_xip`=0, `busy` stays high after reset until two frames have completed. The first frame is the single byte 06h. The second is byte 81h followed by the configuration byte {DUMMY_CYC[3:0], 0 (ready bit), 0, 2'b11}, which is 83h for 8 dummy clocks.
- R2: With `basic_xip`=1, no frame is sent after reset and `busy` falls within three clocks.
- R3: When the flash is not in the continuous-read state and `xip_en`=1, a read frame carries opcode 0Bh, the address, DUMMY_CYC dummy clocks whose first bit on `spi_dq0` is 0, and then 32 data clocks. After this frame the flash counts as being in the continuous-read state.
- R4: While the flash is in the continuous-read state and `xip_en`=1, a read frame carries no opcode. It sends the address and then the dummy clocks, and the first dummy bit is 0.
- R5: With `addr_4b`=1 the address field is all 32 bits of `req_addr`. With `addr_4b`=0 it is `req_addr[23:0]`. All fields are sent MSB first.
- R6: A read with `xip_en`=0 drives the first dummy bit as 1. If the flash was in the continuous-read state, that frame has no opcode and afterwards the state is left. Every later read with `xip_en`=0 carries opcode 0Bh.
- R7: The word is assembled MSB first from `spi_dq1`, so the first data bit becomes `rsp_data[31]`. `rsp_valid` is high for exactly one clock, no more than two clocks after `spi_cs_n` rises at the end of the read frame.
- R8: The serial clock follows mode 0. `spi_sck` is 0 whenever `spi_cs_n` is 1, and `spi_dq0` changes only while `spi_sck` is low, so it holds steady while `spi_sck` is high.
- R9: Between two frames, `spi_cs_n` stays high for at least two system clocks.
- R10: A request is taken only on a clock where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while `busy` is 1 and while a frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| basic_xip | input | 1 | Strap: enter the continuous-read state without a configuration write |
| addr_4b | input | 1 | Strap: send a 32-bit address (1) or a 24-bit address (0) |
| xip_en | input | 1 | Level: 1 uses continuous reads, 0 uses plain reads and leaves the state |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Request can be taken this clock |
| rsp_valid | output | 1 | One-clock pulse marking `rsp_data` valid |
| rsp_data | output | 32 | Word read from the flash |
| busy | output | 1 | Start-up sequence in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_dq0 | output | 1 | Serial data to the flash |
| spi_dq1 | input | 1 | Serial data from the flash |

## Verification
The sequencer's state can go wrong in two main ways, and both show at the serial pins in the very next frame. If the continuous-read flag is wrong, the frame gains or loses eight clocks of opcode. If a bit count is wrong, the dummy window shifts, the confirmation bit lands in the wrong place, and the returned word comes back rotated. The bench models the flash so that it returns data at the bit position that follows from the requirements. A frame that is too long or too short therefore appears as a wrong `rsp_data` as well as a wrong bit count, within one request. A start-up sequencer stuck in its states shows as `busy` never falling, and the bench reports that within a few thousand clocks.

// File: rtl/xip_seq_pkg.sv
package xip_seq_pkg;

  localparam int TXW = 56;   // opcode 8 + address 32 + dummy up to 16
  localparam int CNTW = 7;   // frame bit counter
  localparam int RXLW = 6;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WCFG  = 8'h81;
  localparam logic [7:0] OP_FREAD = 8'h0B;

  typedef enum logic [2:0] {
    C_BOOT, C_WREN, C_WREN_W, C_CFG, C_CFG_W, C_IDLE, C_READ_W
  } ctrl_st_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} ser_st_t;

  // configuration byte: dummy count, ready-for-xip (0), reserved, wrap
  function automatic logic [7:0] cfg_byte(logic [3:0] dummy);
    return {dummy, 1'b0, 1'b0, 2'b11};
  endfunction

  // transmit part of a read frame, left aligned; dummy bits after conf are 0
  function automatic logic [TXW-1:0] read_frame(logic op_en, logic [31:0] addr,
                                                logic a4, logic conf);
    logic [TXW-1:0] v;
    if (a4) v = {OP_FREAD, addr, conf, 15'b0};
    else    v = {OP_FREAD, addr[23:0], conf, 23'b0};
    if (!op_en) v = v << 8;
    return v;
  endfunction

  function automatic logic [CNTW-1:0] read_len(logic op_en, logic a4, logic [3:0] dummy);
    logic [CNTW-1:0] n;
    n = a4 ? 7'd32 : 7'd24;
    if (op_en) n = n + 7'd8;
    return n + {3'b000, dummy};
  endfunction

endpackage

// File: rtl/xip_serdes.sv
module xip_serdes
  import xip_seq_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TXW-1:0]   tx_vec,
  input  logic [CNTW-1:0]  tx_len,
  input  logic [RXLW-1:0]  rx_len,
  output logic             ready,
  output logic             done,
  output logic [31:0]      rx_word,
  output logic             cs_n,
  output logic             sck,
  output logic             dq0,
  input  logic             dq1
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  ser_st_t         st;
  logic [TXW-1:0]  shreg;
  logic [CNTW-1:0] txl, tot, idx;
  logic [GW-1:0]   gcnt;

  // named events for the checks
  logic bit_fall, last_bit;
  assign bit_fall = (st == S_RUN) && sck;
  assign last_bit = bit_fall && (idx == tot - 1'b1);
  assign ready    = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; txl <= '0; tot <= '0; idx <= '0; gcnt <= '0;
      rx_word <= '0; cs_n <= 1'b1; sck <= 1'b0; dq0 <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          shreg   <= tx_vec << 1;
          dq0     <= tx_vec[TXW-1];
          txl     <= tx_len;
          tot     <= tx_len + CNTW'(rx_len);
          idx     <= '0;
          rx_word <= '0;
          cs_n    <= 1'b0;
          st      <= S_RUN;
        end
        S_RUN: begin
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            if (idx >= txl) rx_word <= {rx_word[30:0], dq1};
            if (last_bit) begin
              st <= S_GAP; cs_n <= 1'b1; dq0 <= 1'b0; done <= 1'b1; gcnt <= '0;
            end else begin
              idx   <= idx + 1'b1;
              dq0   <= shreg[TXW-1];
              shreg <= shreg << 1;
            end
          end
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) st <= S_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sck_low_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_dq0_steady_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(dq0));
  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !sck);

endmodule

// File: rtl/xip_ctrl.sv
module xip_ctrl
  import xip_seq_pkg::*;
#(
  parameter int DUMMY_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             basic_xip,
  input  logic             addr_4b,
  input  logic             xip_en,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             busy,
  output logic             ser_start,
  output logic [TXW-1:0]   ser_tx,
  output logic [CNTW-1:0]  ser_txl,
  output logic [RXLW-1:0]  ser_rxl,
  input  logic             ser_ready,
  input  logic             ser_done,
  input  logic [31:0]      ser_rx
);
  localparam logic [3:0] DUMMY4 = 4'(DUMMY_CYC);

  ctrl_st_t st;
  logic     in_xip, pend_xip;
  logic     rd_fire;

  assign busy    = (st == C_BOOT) || (st == C_WREN) || (st == C_WREN_W) ||
                   (st == C_CFG)  || (st == C_CFG_W);
  assign rd_fire = (st == C_IDLE) && ser_start;

  always_comb begin
    ser_start = 1'b0;
    ser_tx    = '0;
    ser_txl   = '0;
    ser_rxl   = '0;
    req_ready = 1'b0;
    case (st)
      C_WREN: begin
        ser_start = ser_ready;
        ser_tx    = {OP_WREN, {(TXW-8){1'b0}}};
        ser_txl   = 7'd8;
      end
      C_CFG: begin
        ser_start = ser_ready;
        ser_tx    = {OP_WCFG, cfg_byte(DUMMY4), {(TXW-16){1'b0}}};
        ser_txl   = 7'd16;
      end
      C_IDLE: begin
        req_ready = ser_ready;
        ser_start = req_valid && ser_ready;
        ser_tx    = read_frame(!in_xip, req_addr, addr_4b, !xip_en);
        ser_txl   = read_len(!in_xip, addr_4b, DUMMY4);
        ser_rxl   = 6'd32;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= C_BOOT; in_xip <= 1'b0; pend_xip <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        C_BOOT:   st <= basic_xip ? C_IDLE : C_WREN;
        C_WREN:   if (ser_start) st <= C_WREN_W;
        C_WREN_W: if (ser_done)  st <= C_CFG;
        C_CFG:    if (ser_start) st <= C_CFG_W;
        C_CFG_W:  if (ser_done)  st <= C_IDLE;
        C_IDLE:   if (rd_fire) begin
          pend_xip <= xip_en;
          st       <= C_READ_W;
        end
        C_READ_W: if (ser_done) begin
          rsp_valid <= 1'b1;
          rsp_data  <= ser_rx;
          in_xip    <= pend_xip;
          st        <= C_IDLE;
        end
        default: st <= C_BOOT;
      endcase
    end
  end

  p_busy_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  p_start_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |-> ser_ready);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_xip_flag_at_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_xip) |-> $past(ser_done));
  p_rsp_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ser_done));

endmodule

// File: rtl/xip_read_seq.sv
module xip_read_seq
  import xip_seq_pkg::*;
#(
  parameter int DUMMY_CYC = 8,
  parameter int GAP_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        basic_xip,
  input  logic        addr_4b,
  input  logic        xip_en,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        busy,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_dq0,
  input  logic        spi_dq1
);
  logic            ser_start, ser_ready, ser_done;
  logic [TXW-1:0]  ser_tx;
  logic [CNTW-1:0] ser_txl;
  logic [RXLW-1:0] ser_rxl;
  logic [31:0]     ser_rx;

  xip_ctrl #(.DUMMY_CYC(DUMMY_CYC)) u_ctrl (
    .clk, .rst_n, .basic_xip, .addr_4b, .xip_en,
    .req_valid, .req_addr, .req_ready, .rsp_valid, .rsp_data, .busy,
    .ser_start, .ser_tx, .ser_txl, .ser_rxl, .ser_ready, .ser_done, .ser_rx
  );

  xip_serdes #(.GAP_CYC(GAP_CYC)) u_serdes (
    .clk, .rst_n, .start(ser_start), .tx_vec(ser_tx), .tx_len(ser_txl),
    .rx_len(ser_rxl), .ready(ser_ready), .done(ser_done), .rx_word(ser_rx),
    .cs_n(spi_cs_n), .sck(spi_sck), .dq0(spi_dq0), .dq1(spi_dq1)
  );

  p_ready_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

endmodule

// File: tb/xip_read_seq_tb.sv
module xip_read_seq_tb;
  localparam int DUMMY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic basic_xip = 1'b0, addr_4b = 1'b0, xip_en = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, busy, spi_cs_n, spi_sck, spi_dq0;
  logic spi_dq1 = 1'b0;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xip_read_seq #(.DUMMY_CYC(DUMMY)) u_dut (
    .clk, .rst_n, .basic_xip, .addr_4b, .xip_en, .req_valid, .req_addr,
    .req_ready, .rsp_valid, .rsp_data, .busy,
    .spi_cs_n, .spi_sck, .spi_dq0, .spi_dq1
  );

  // ---------------- flash model: records frames, returns data ----------
  int           m_txlen = 0;
  logic [31:0]  m_data = '0;
  int           frames = 0, nbits = 0, last_n = 0, prev_n = 0;
  logic [127:0] cap = '0, last_cap = '0, prev_cap = '0;
  logic         ps = 1'b0, pc = 1'b1;

  function automatic logic dbit(int k);
    if (k >= m_txlen && k < m_txlen + 32) return m_data[31 - (k - m_txlen)];
    return 1'b0;
  endfunction

  always @(spi_sck or spi_cs_n) begin
    if (pc && !spi_cs_n) begin nbits = 0; cap = '0; spi_dq1 = dbit(0); end
    else if (!pc && spi_cs_n) begin
      frames = frames + 1;
      prev_n = last_n; prev_cap = last_cap; last_n = nbits; last_cap = cap;
    end
    if (!spi_cs_n && !ps && spi_sck) begin cap = {cap[126:0], spi_dq0}; nbits = nbits + 1; end
    if (!spi_cs_n && ps && !spi_sck) spi_dq1 = dbit(nbits);
    ps = spi_sck; pc = spi_cs_n;
  end

  // chip-select high time between frames (R9)
  int hi = 0, min_gap = 1000;
  always @(negedge clk) begin
    if (spi_cs_n) hi = hi + 1;
    else begin
      if (frames > 0 && hi > 0 && hi < min_gap) min_gap = hi;
      hi = 0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=%0d expected=<150000", wd);
      finish_run();
    end
  end

  task automatic do_reset(input logic basic, input logic a4);
    rst_n = 1'b0; basic_xip = basic; addr_4b = a4; xip_en = 1'b1; req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset cs_n", 64'(spi_cs_n), 64'd1);
    check("R1 reset sck", 64'(spi_sck), 64'd0);
    check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
  endtask

  // one read request, expected frame computed from the requirements
  task automatic do_read(input logic [31:0] addr, input logic xen, input logic [31:0] data,
                         input logic op, input logic conf, input logic a4, input string tag);
    int alen, hlen, n, t, f0;
    logic [63:0] hdr, got;
    alen = a4 ? 32 : 24;
    hlen = (op ? 8 : 0) + alen;
    m_txlen = hlen + DUMMY;
    m_data = data;
    hdr = op ? 64'h0B : 64'h0;
    hdr = (hdr << alen) | (a4 ? 64'(addr) : 64'(addr[23:0]));
    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); t++; end
    f0 = frames;
    xip_en = xen; req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R10 ready low in frame"}, 64'(req_ready), 64'd0);
    t = 0;
    while (frames == f0 && t < 5000) begin @(negedge clk); t++; end
    n = 1;
    while (!rsp_valid && n < 10) begin @(negedge clk); n++; end
    check({tag, " R7 rsp latency"}, 64'(n <= 2 && rsp_valid), 64'd1);
    check({tag, " R7 data MSB first"}, 64'(rsp_data), 64'(data));
    check({tag, " R3 frame bits"}, 64'(last_n), 64'(m_txlen + 32));
    got = 64'((last_cap >> (32 + DUMMY)) & ((128'd1 << hlen) - 1));
    check({tag, " R5 header"}, got, hdr);
    check({tag, " R4 conf bit"}, 64'(last_cap[32 + DUMMY - 1]), 64'(conf));
    @(negedge clk);
    check({tag, " R7 pulse one cycle"}, 64'(rsp_valid), 64'd0);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        xen;
    logic [31:0] data;
    logic        op;
    logic        conf;
  } vec_t;

  // entry (R3), continuous (R4), exit and plain (R6), re-entry
  localparam vec_t VEC [7] = '{
    '{32'h0012_3456, 1'b1, 32'hA5C3_0F1E, 1'b1, 1'b0},
    '{32'h00AB_CDEF, 1'b1, 32'h1234_5678, 1'b0, 1'b0},
    '{32'hFF00_FF00, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{32'h0000_0010, 1'b0, 32'h0000_0001, 1'b0, 1'b1},
    '{32'h0000_0020, 1'b0, 32'h8000_0000, 1'b1, 1'b1},
    '{32'h00FF_FFFF, 1'b1, 32'h5A5A_C3C3, 1'b1, 1'b0},
    '{32'h0000_0004, 1'b1, 32'h0F0F_F0F0, 1'b0, 1'b0}
  };

  initial begin
    int t, f0;
    // ---- start-up with configuration write (R1, R10) ----
    do_reset(1'b0, 1'b0);
    f0 = frames;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd1);
    check("R10 ready low while busy", 64'(req_ready), 64'd0);
    t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    check("R1 busy falls", 64'(busy), 64'd0);
    check("R1 two init frames", 64'(frames - f0), 64'd2);
    check("R1 wren length", 64'(prev_n), 64'd8);
    check("R1 wren opcode", 64'(prev_cap[7:0]), 64'h06);
    check("R1 cfg length", 64'(last_n), 64'd16);
    check("R1 cfg bytes", 64'(last_cap[15:0]), 64'h8183);

    // ---- table of reads, 24-bit address ----
    for (int i = 0; i < 7; i++)
      do_read(VEC[i].addr, VEC[i].xen, VEC[i].data, VEC[i].op, VEC[i].conf, 1'b0, "tbl");

    // ---- direct-entry parts with 32-bit address (R2, R5) ----
    do_reset(1'b1, 1'b1);
    f0 = frames;
    repeat (3) @(negedge clk);
    check("R2 busy low quickly", 64'(busy), 64'd0);
    check("R2 no init frame", 64'(frames - f0), 64'd0);
    do_read(32'h89AB_CDEF, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, "basic entry");
    do_read(32'h0123_4567, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, "basic xip");
    do_read(32'hFFFF_FFFC, 1'b0, 32'h7654_3210, 1'b0, 1'b1, 1'b1, "basic exit");

    check("R9 min cs high", 64'(min_gap >= 2), 64'd1);
    check("R8 sck idle low", 64'(spi_sck), 64'd0);
    finish_run();
  end
endmodule